// File: doc/BRIEF.md
# Interrupt request flag controller

This block keeps the pending-request flags of a small microcontroller interrupt system and applies a separate set and clear policy to each source. Two external pins arrive through a two-stage synchronizer. Each pin is either falling-edge latched or level-followed. A configurable number of timer overflow pulses set flags that clear when the CPU acknowledges them. A serial port raises one request from separate receive and transmit flags. An ADC done strobe can be gated by a compare stage.

The CPU acknowledge carries a vector index. Only the flags whose policy is clear-on-acknowledge react to it. Software reads and writes the flags through a small byte register port. The block drives one request line per source; priority and vectoring are handled downstream.

Vector indices: 0 and 1 are the external pins, 2 to NTIMER+1 are the timers, NTIMER+2 is the serial port and NTIMER+3 is the ADC. `irq_req` uses the same bit order.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all three registers read 0 and `irq_req` is 0, provided the pins are high.
- R2: Register 0 holds the external pin configuration: bit 0 is the pin 0 mode, bit 1 is the pin 0 flag, bit 2 is the pin 1 mode and bit 3 is the pin 1 flag; bits 7:4 read 0. Register 1 bit t is the flag of timer t. Register 2 holds receive at bit 0, transmit at bit 1 and ADC at bit 2.
- R3: A mode bit of 1 selects edge mode. In edge mode a falling edge on the pin sets the latched flag. The flag becomes visible on the third rising clock edge after the pin changes, and it stays set after the pin returns high.
- R4: An edge-mode external flag clears when an acknowledge arrives with that pin's vector index.
- R5: A mode bit of 0 selects level mode. In level mode the request is high while the synchronized pin is low, two clock edges after the pin changes, and it is not latched. The register flag bit reads that live condition, and software writes to it are ignored.
- R6: A timer overflow pulse sets that timer's flag. An acknowledge with that timer's vector index clears it.
- R7: The serial request is the OR of the receive and transmit flags. An acknowledge leaves both flags unchanged.
- R8: With compare disabled, every ADC done strobe sets the ADC flag. With compare enabled, a strobe sets the flag only if the result is strictly greater than the compare value; an equal or smaller result leaves the flag unchanged. An acknowledge does not clear the ADC flag.
- R9: A hardware set event in the same cycle as a software write or an acknowledge clear leaves the flag set.
- R10: A software write loads the written value into the timer, serial, ADC and edge-mode external flags. A 1 sets the flag and a 0 clears it.
- R11: An acknowledge whose vector index belongs to a different source leaves a flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 2 | External interrupt pins, idle high |
| tmr_ovf | input | NTIMER | Timer overflow pulses |
| ser_rx_done | input | 1 | Serial receive complete pulse |
| ser_tx_done | input | 1 | Serial transmit complete pulse |
| adc_done | input | 1 | ADC conversion done strobe |
| adc_result | input | ADC_W | Conversion result |
| adc_cmp_val | input | ADC_W | Compare threshold |
| adc_cmp_en | input | 1 | Compare gate enable |
| ack | input | 1 | CPU interrupt acknowledge strobe |
| ack_vec | input | VW | Vector index being acknowledged |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_req | output | NSRC | Per-source request lines |

## Verification
The bench builds the block with NTIMER=3 and ADC_W=4. The narrow result width makes the compare boundaries easy to reach, including equal values, all-ones results and a zero compare value. Three timers are enough for the timer vectors to sit between the external and serial vectors, so an acknowledge aimed at a neighbouring index can be tested against each policy.

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl #(
  parameter  int NTIMER = 3,
  parameter  int ADC_W  = 10,
  localparam int NSRC   = NTIMER + 4,
  localparam int VW     = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ext_pin,
  input  logic [NTIMER-1:0] tmr_ovf,
  input  logic              ser_rx_done,
  input  logic              ser_tx_done,
  input  logic              adc_done,
  input  logic [ADC_W-1:0]  adc_result,
  input  logic [ADC_W-1:0]  adc_cmp_val,
  input  logic              adc_cmp_en,
  input  logic              ack,
  input  logic [VW-1:0]     ack_vec,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NSRC-1:0]   irq_req
);

  logic [1:0] s1, s2, s3;
  logic [1:0] mode_q, eflag_q;
  logic [NTIMER-1:0] tmr_q;
  logic rx_q, tx_q, adc_q;
  logic [NSRC-1:0] ackv;
  logic unused_wbits;

  wire [1:0] fall    = s3 & ~s2;
  wire [1:0] pend    = (mode_q & eflag_q) | (~mode_q & ~s2);
  wire       wr0     = reg_wr && reg_addr == 2'd0;
  wire       wr1     = reg_wr && reg_addr == 2'd1;
  wire       wr2     = reg_wr && reg_addr == 2'd2;
  wire       adc_set = adc_done && (!adc_cmp_en || adc_result > adc_cmp_val);

  assign unused_wbits = ^reg_wdata[7:4];

  always_comb
    for (int i = 0; i < NSRC; i++) ackv[i] = ack && ack_vec == VW'(i);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
      s3 <= 2'b11;
    end else begin
      s1 <= ext_pin;
      s2 <= s1;
      s3 <= s2;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q  <= '0;
      eflag_q <= '0;
    end else begin
      if (wr0) mode_q <= {reg_wdata[2], reg_wdata[0]};
      for (int i = 0; i < 2; i++)
        if (!mode_q[i])   eflag_q[i] <= 1'b0;
        else if (fall[i]) eflag_q[i] <= 1'b1;
        else if (wr0)     eflag_q[i] <= reg_wdata[2*i+1];
        else if (ackv[i]) eflag_q[i] <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tmr_q <= '0;
    else
      for (int t = 0; t < NTIMER; t++)
        if (tmr_ovf[t])     tmr_q[t] <= 1'b1;
        else if (wr1)       tmr_q[t] <= reg_wdata[t];
        else if (ackv[2+t]) tmr_q[t] <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
      adc_q <= 1'b0;
    end else begin
      if (ser_rx_done) rx_q <= 1'b1;
      else if (wr2)    rx_q <= reg_wdata[0];
      if (ser_tx_done) tx_q <= 1'b1;
      else if (wr2)    tx_q <= reg_wdata[1];
      if (adc_set)     adc_q <= 1'b1;
      else if (wr2)    adc_q <= reg_wdata[2];
    end

  assign irq_req = {adc_q, rx_q | tx_q, tmr_q, pend};

  always_comb
    case (reg_addr)
      2'd0:    reg_rdata = {4'b0, pend[1], mode_q[1], pend[0], mode_q[0]};
      2'd1:    reg_rdata = 8'(tmr_q);
      2'd2:    reg_rdata = {5'b0, adc_q, tx_q, rx_q};
      default: reg_rdata = 8'h00;
    endcase

  a_r3_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && fall[0]) |=> eflag_q[0]);

  a_r4_edge_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] && ack && ack_vec == VW'(0) && !fall[0] && !wr0) |=> !eflag_q[0]);

  a_r5_level_nolatch: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q[1] |=> !eflag_q[1]);

  a_r7_ser_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_q && !wr2) |=> rx_q);

  a_r8_adc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_q && adc_done && adc_cmp_en && adc_result <= adc_cmp_val && !wr2) |=> !adc_q);

  for (genvar t = 0; t < NTIMER; t++) begin : g_tchk
    a_r6_tmr_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && ack_vec == VW'(2+t) && !tmr_ovf[t] && !wr1) |=> !tmr_q[t]);
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[t] |=> tmr_q[t]);
  end

endmodule

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
  localparam int NT = 3;
  localparam int AW = 4;
  localparam int NS = NT + 4;
  localparam int VW = $clog2(NS);

  logic clk = 0, rst_n = 0;
  logic [1:0] ext_pin = 2'b11;
  logic [NT-1:0] tmr_ovf = '0;
  logic ser_rx_done = 0, ser_tx_done = 0, adc_done = 0, adc_cmp_en = 0, ack = 0, reg_wr = 0;
  logic [AW-1:0] adc_result = '0, adc_cmp_val = '0;
  logic [VW-1:0] ack_vec = '0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [NS-1:0] irq_req;
  int errors = 0, checks = 0;
  bit finished = 0;

  irq_flag_ctrl #(.NTIMER(NT), .ADC_W(AW)) i_irq_flag_ctrl (
    .clk, .rst_n, .ext_pin, .tmr_ovf, .ser_rx_done, .ser_tx_done, .adc_done,
    .adc_result, .adc_cmp_val, .adc_cmp_en, .ack, .ack_vec, .reg_addr,
    .reg_wr, .reg_wdata, .reg_rdata, .irq_req);

  always #10 clk = ~clk;

  // {cmp_en, result, compare, expected flag}
  localparam logic [9:0] ADC_VEC [8] = '{
    {1'b0, 4'd3,  4'd9,  1'b1},
    {1'b1, 4'd3,  4'd9,  1'b0},
    {1'b1, 4'd9,  4'd9,  1'b0},
    {1'b1, 4'd10, 4'd9,  1'b1},
    {1'b1, 4'd15, 4'd14, 1'b1},
    {1'b1, 4'd0,  4'd0,  1'b0},
    {1'b1, 4'd15, 4'd15, 1'b0},
    {1'b0, 4'd0,  4'd15, 1'b1}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    step(1);
    reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1 chk(req, reg_rdata, exp);
  endtask

  task automatic do_ack(input int v);
    ack = 1; ack_vec = VW'(v);
    step(1);
    ack = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    // R1 reset
    rd("R1", 2'd0, 8'h00);
    rd("R1", 2'd1, 8'h00);
    rd("R1", 2'd2, 8'h00);
    chk("R1", 8'(irq_req), 8'h00);

    // R5 level mode tracking
    ext_pin[0] = 0;
    step(1);
    chk("R5", 8'(irq_req[0]), 8'h00);
    step(1);
    chk("R5", 8'(irq_req[0]), 8'h01);
    rd("R5 R2", 2'd0, 8'h02);
    ext_pin[0] = 1;
    step(2);
    chk("R5", 8'(irq_req[0]), 8'h00);
    wr(2'd0, 8'h02);
    rd("R5", 2'd0, 8'h00);
    chk("R5", 8'(irq_req[0]), 8'h00);

    // R3 edge set, R11, R4 ack clear
    wr(2'd0, 8'h01);
    ext_pin[0] = 0;
    step(2);
    chk("R3", 8'(irq_req[0]), 8'h00);
    step(1);
    chk("R3", 8'(irq_req[0]), 8'h01);
    ext_pin[0] = 1;
    step(3);
    rd("R3 R2", 2'd0, 8'h03);
    do_ack(1);
    chk("R11", 8'(irq_req[0]), 8'h01);
    do_ack(0);
    chk("R4", 8'(irq_req[0]), 8'h00);
    rd("R4", 2'd0, 8'h01);
    wr(2'd0, 8'h05);
    ext_pin[1] = 0;
    step(3);
    ext_pin[1] = 1;
    rd("R3 R2", 2'd0, 8'h0D);
    do_ack(1);
    chk("R4", 8'(irq_req[1]), 8'h00);
    wr(2'd0, 8'h07);
    rd("R10", 2'd0, 8'h07);
    wr(2'd0, 8'h05);
    rd("R10", 2'd0, 8'h05);

    // R6 timers, R9, R10
    tmr_ovf[1] = 1; step(1); tmr_ovf[1] = 0;
    rd("R6 R2", 2'd1, 8'h02);
    chk("R6", 8'(irq_req[3]), 8'h01);
    do_ack(2);
    chk("R11", 8'(irq_req[3]), 8'h01);
    do_ack(3);
    chk("R6", 8'(irq_req[3]), 8'h00);
    tmr_ovf[2] = 1; ack = 1; ack_vec = VW'(4);
    step(1);
    tmr_ovf[2] = 0; ack = 0;
    rd("R9", 2'd1, 8'h04);
    wr(2'd1, 8'h01);
    rd("R10", 2'd1, 8'h01);
    wr(2'd1, 8'h00);
    rd("R10", 2'd1, 8'h00);

    // R7 serial
    ser_rx_done = 1; step(1); ser_rx_done = 0;
    chk("R7", 8'(irq_req[5]), 8'h01);
    do_ack(5);
    rd("R7", 2'd2, 8'h01);
    ser_tx_done = 1; step(1); ser_tx_done = 0;
    rd("R7", 2'd2, 8'h03);
    wr(2'd2, 8'h02);
    chk("R7", 8'(irq_req[5]), 8'h01);
    wr(2'd2, 8'h00);
    chk("R10", 8'(irq_req[5]), 8'h00);
    ser_rx_done = 1; reg_addr = 2'd2; reg_wdata = 8'h00; reg_wr = 1;
    step(1);
    ser_rx_done = 0; reg_wr = 0;
    rd("R9", 2'd2, 8'h01);
    wr(2'd2, 8'h00);

    // R8 ADC compare gate table
    for (int k = 0; k < 8; k++) begin
      wr(2'd2, 8'h00);
      adc_cmp_en  = ADC_VEC[k][9];
      adc_result  = ADC_VEC[k][8:5];
      adc_cmp_val = ADC_VEC[k][4:1];
      adc_done = 1; step(1); adc_done = 0;
      chk("R8", 8'(irq_req[6]), 8'(ADC_VEC[k][0]));
    end
    do_ack(6);
    rd("R8", 2'd2, 8'h04);
    wr(2'd2, 8'h00);
    rd("R8", 2'd2, 8'h00);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule